// File: doc/BRIEF.md
# Dual-Pool SRAM Block Allocator

This block hands out fixed regions of two on-chip sample buffers to DMA channels. One buffer serves transmit (memory-to-device) traffic and the other serves every other direction. Each buffer is cut into 2048-byte blocks. The buffer's byte size comes from a size input and is captured while reset is held. One occupancy bitmap per buffer records which blocks are in use. An allocate request takes the lowest free block of the chosen buffer and returns a 32-bit region descriptor. The upper half of the descriptor is the region size and the lower half is the region byte base. A free request returns a block to the buffer by decoding the base field of the descriptor it carries.

Requests come in over a valid/ready handshake and are served one at a time. The allocator takes one request per cycle whenever `req_ready` is high. `req_ready` is low only during reset and in the first cycle after reset. A requester that sees `req_ready` low holds its request stable until a cycle in which both signals are high. The result is a one-cycle pulse and it cannot be stalled. Each successful allocation also writes its descriptor into a per-channel register, and that register can be read back at any time on a separate read port.

Top module: `sram_block_alloc`

## Requirements
- R1: While `rst_n` is low, both bitmaps and all per-channel descriptor registers are cleared and `rsp_done` is low. `req_ready` is low during reset and rises in the second cycle after reset is released.
- R2: A buffer's usable block count is its byte size divided by 2048, rounded down and limited to 32. The size is captured only while reset is held, so later changes on the size inputs have no effect.
- R3: An allocation that succeeds takes the lowest-numbered free block i among the usable blocks. It returns the descriptor {16'h0800, i×2048}, with the size in bits 31:16 and the base in bits 15:0, and marks block i as used.
- R4: When no usable block is free, an allocation returns `rsp_busy`=1 and a descriptor of zero. The bitmap and the channel registers do not change.
- R5: `req_dir`=1 (transmit) selects the transmit buffer and `req_dir`=0 selects the receive buffer. A request never changes the other buffer.
- R6: A free request with base field b < the buffer byte size clears bitmap bit b/2048 (integer division). That block then becomes available to later allocations. The response carries a descriptor of zero.
- R7: A free request whose base field is at or above the buffer byte size returns `rsp_err`=1 and leaves the bitmap unchanged.
- R8: A successful allocation writes its descriptor into the register of `req_chan`. `rd_desc` shows the register selected by `rd_chan`. Busy allocations and free requests do not write any channel register.
- R9: A request is accepted on a cycle where `req_valid` and `req_ready` are both high. `rsp_done` pulses for exactly one cycle on the cycle after acceptance and at no other time. `rsp_busy` and `rsp_err` can be high only together with `rsp_done`. `req_op`=0 means allocate and `req_op`=1 means free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the buffer sizes are captured while it is low |
| tx_pool_bytes | input | 17 | Byte size of the transmit buffer |
| rx_pool_bytes | input | 17 | Byte size of the receive buffer |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Allocator can accept a request |
| req_op | input | 1 | 0 = allocate, 1 = free |
| req_dir | input | 1 | 1 = transmit buffer, 0 = receive buffer |
| req_chan | input | 6 | Channel whose register an allocation writes |
| req_desc | input | 32 | Descriptor to release (free requests only) |
| rsp_done | output | 1 | One-cycle result strobe |
| rsp_busy | output | 1 | Allocation failed because the buffer is full |
| rsp_err | output | 1 | Free rejected because the base is out of range |
| rsp_desc | output | 32 | Descriptor granted by an allocation, zero otherwise |
| rd_chan | input | 6 | Channel register to read |
| rd_desc | output | 32 | Contents of the selected channel register |

## Verification
The bench runs two reset phases. The first uses a transmit size that is not a whole number of blocks (5000 bytes, 2 blocks) and a receive buffer of the full 64 KiB. The second uses a zero-size transmit buffer and a 7-block receive buffer. Directed sequences fill a buffer, overflow it, release a block in the middle and allocate again. These show the lowest-free search, the busy path and the reuse of freed blocks. Random mixes of allocates and frees, including frees whose base lies beyond the buffer, are checked against a bench model. They separate the two buffers, the out-of-range rejection and the channel-register writes from one another.

// File: rtl/sba_pkg.sv
package sba_pkg;
  localparam int unsigned FIELD_W = 16;
  localparam int unsigned DESC_W  = 2 * FIELD_W;

  typedef enum logic { OP_ALLOC = 1'b0, OP_FREE = 1'b1 } op_e;
  typedef enum logic { DIR_RX = 1'b0, DIR_TX = 1'b1 } dir_e;

  typedef struct packed {
    logic [FIELD_W-1:0] len;
    logic [FIELD_W-1:0] base;
  } region_t;
endpackage

// File: rtl/sba_lsb_free.sv
module sba_lsb_free #(
  parameter int unsigned N = 32,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  free_vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

  logic [N-1:0] below_idx;
  assign below_idx = (N'(1) << idx) - N'(1);

  always_comb begin
    if (found) begin
      assert_pick_lowest_R3: assert (free_vec[idx] && ((free_vec & below_idx) == '0));
    end else begin
      assert_none_free_R4: assert (free_vec == '0);
    end
  end
endmodule

// File: rtl/sba_pool.sv
module sba_pool import sba_pkg::*; #(
  parameter int unsigned MAP_BITS  = 32,
  parameter int unsigned SIZE_W    = 17,
  parameter int unsigned BLK_SHIFT = 11,
  localparam int unsigned IW    = $clog2(MAP_BITS),
  localparam int unsigned CNT_W = SIZE_W - BLK_SHIFT
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SIZE_W-1:0]   size_in,
  input  logic                alloc_en,
  input  logic                free_en,
  input  logic [FIELD_W-1:0]  free_base,
  output logic                found,
  output logic [IW-1:0]       alloc_idx,
  output logic                base_ok,
  output logic [MAP_BITS-1:0] map_q
);
  logic [SIZE_W-1:0]   size_q;
  logic [CNT_W-1:0]    blk_cnt;
  logic [MAP_BITS-1:0] usable;
  logic [MAP_BITS-1:0] free_vec;
  logic [IW-1:0]       free_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) size_q <= size_in;
  end

  assign blk_cnt = size_q[SIZE_W-1:BLK_SHIFT];

  for (genvar g = 0; g < MAP_BITS; g++) begin : g_usable
    assign usable[g] = 32'(blk_cnt) > 32'(g);
  end

  assign free_vec = ~map_q & usable;

  sba_lsb_free #(.N(MAP_BITS)) u_find (
    .free_vec (free_vec),
    .found    (found),
    .idx      (alloc_idx)
  );

  assign free_idx = IW'(free_base >> BLK_SHIFT);
  assign base_ok  = 32'(free_base) < 32'(size_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q <= '0;
    end else if (alloc_en && found) begin
      map_q[alloc_idx] <= 1'b1;
    end else if (free_en && base_ok) begin
      map_q[free_idx] <= 1'b0;
    end
  end

  assert_map_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (map_q & ~usable) == '0);

  assert_busy_keeps_map_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_en && !found) |=> $stable(map_q));

  assert_bad_free_keeps_map_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (free_en && !base_ok) |=> $stable(map_q));

  assert_freed_bit_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (free_en && base_ok) |=> !map_q[$past(free_idx)]);
endmodule

// File: rtl/sba_desc_rf.sv
module sba_desc_rf #(
  parameter int unsigned NCHAN = 64,
  parameter int unsigned W     = 32,
  localparam int unsigned AW   = $clog2(NCHAN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] regs [NCHAN];

  for (genvar c = 0; c < NCHAN; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs[c] <= '0;
      else if (wr_en && (wr_addr == AW'(c))) regs[c] <= wr_data;
    end
  end

  assign rd_data = regs[rd_addr];
endmodule

// File: rtl/sram_block_alloc.sv
module sram_block_alloc import sba_pkg::*; #(
  parameter int unsigned NCHAN       = 64,
  parameter int unsigned SIZE_W      = 17,
  parameter int unsigned BLOCK_BYTES = 2048,
  parameter int unsigned MAP_BITS    = 32,
  localparam int unsigned CH_W      = $clog2(NCHAN),
  localparam int unsigned BLK_SHIFT = $clog2(BLOCK_BYTES),
  localparam int unsigned IW        = $clog2(MAP_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SIZE_W-1:0] tx_pool_bytes,
  input  logic [SIZE_W-1:0] rx_pool_bytes,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_op,
  input  logic              req_dir,
  input  logic [CH_W-1:0]   req_chan,
  input  logic [DESC_W-1:0] req_desc,
  output logic              rsp_done,
  output logic              rsp_busy,
  output logic              rsp_err,
  output logic [DESC_W-1:0] rsp_desc,
  input  logic [CH_W-1:0]   rd_chan,
  output logic [DESC_W-1:0] rd_desc
);
  logic rdy_q;
  logic fire;
  logic is_alloc;
  logic [1:0] p_alloc, p_free, p_found, p_ok;
  logic [IW-1:0]       p_idx [2];
  logic [MAP_BITS-1:0] p_map [2];
  logic [SIZE_W-1:0]   p_size [2];
  region_t in_reg, grant_reg;
  logic grant;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end
  assign req_ready = rdy_q;
  assign fire      = req_valid && req_ready;
  assign is_alloc  = (op_e'(req_op) == OP_ALLOC);
  assign in_reg    = region_t'(req_desc);

  assign p_size[DIR_RX] = rx_pool_bytes;
  assign p_size[DIR_TX] = tx_pool_bytes;

  for (genvar g = 0; g < 2; g++) begin : g_pool
    assign p_alloc[g] = fire &&  is_alloc && (req_dir == 1'(g));
    assign p_free[g]  = fire && !is_alloc && (req_dir == 1'(g));

    sba_pool #(
      .MAP_BITS  (MAP_BITS),
      .SIZE_W    (SIZE_W),
      .BLK_SHIFT (BLK_SHIFT)
    ) u_pool (
      .clk       (clk),
      .rst_n     (rst_n),
      .size_in   (p_size[g]),
      .alloc_en  (p_alloc[g]),
      .free_en   (p_free[g]),
      .free_base (in_reg.base),
      .found     (p_found[g]),
      .alloc_idx (p_idx[g]),
      .base_ok   (p_ok[g]),
      .map_q     (p_map[g])
    );
  end

  assign grant          = fire && is_alloc && p_found[req_dir];
  assign grant_reg.len  = FIELD_W'(BLOCK_BYTES);
  assign grant_reg.base = FIELD_W'(p_idx[req_dir]) << BLK_SHIFT;

  sba_desc_rf #(.NCHAN(NCHAN), .W(DESC_W)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (grant),
    .wr_addr (req_chan),
    .wr_data (grant_reg),
    .rd_addr (rd_chan),
    .rd_data (rd_desc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_done <= 1'b0;
      rsp_busy <= 1'b0;
      rsp_err  <= 1'b0;
      rsp_desc <= '0;
    end else begin
      rsp_done <= fire;
      rsp_busy <= fire && is_alloc && !p_found[req_dir];
      rsp_err  <= fire && !is_alloc && !p_ok[req_dir];
      rsp_desc <= grant ? DESC_W'(grant_reg) : '0;
    end
  end

  assert_done_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rsp_done);

  assert_done_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> $past(fire));

  assert_flag_needs_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_busy || rsp_err) |-> rsp_done);

  assert_tx_spares_rx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_dir) |=> $stable(p_map[DIR_RX]));

  assert_rx_spares_tx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !req_dir) |=> $stable(p_map[DIR_TX]));

  assert_grant_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && !rsp_busy && $past(fire && is_alloc)) |->
      (rsp_desc[DESC_W-1:FIELD_W] == FIELD_W'(BLOCK_BYTES)) &&
      (rsp_desc[BLK_SHIFT-1:0] == '0));
endmodule

// File: tb/test_sram_block_alloc.sv
module test_sram_block_alloc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [16:0] tx_pool_bytes = '0, rx_pool_bytes = '0;
  logic        req_valid = 1'b0, req_op = 1'b0, req_dir = 1'b0;
  logic [5:0]  req_chan = '0, rd_chan = '0;
  logic [31:0] req_desc = '0;
  logic        req_ready, rsp_done, rsp_busy, rsp_err;
  logic [31:0] rsp_desc, rd_desc;

  int nchecks = 0, nfail = 0;
  bit finished = 0;
  logic [31:0] mmap [2];
  int          msize [2];
  logic [31:0] mreg [64];

  always #4 clk = ~clk;

  sram_block_alloc i_sram_block_alloc (
    .clk(clk), .rst_n(rst_n), .tx_pool_bytes(tx_pool_bytes), .rx_pool_bytes(rx_pool_bytes),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_dir(req_dir),
    .req_chan(req_chan), .req_desc(req_desc), .rsp_done(rsp_done), .rsp_busy(rsp_busy),
    .rsp_err(rsp_err), .rsp_desc(rsp_desc), .rd_chan(rd_chan), .rd_desc(rd_desc));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int first_free(logic [31:0] m, int bytes);
    int nb = bytes / 2048;
    if (nb > 32) nb = 32;
    for (int i = 0; i < nb; i++) if (!m[i]) return i;
    return -1;
  endfunction

  // R1 R2: reset with new sizes, then disturb the size inputs
  task automatic do_reset(int txb, int rxb);
    rst_n = 1'b0;
    tx_pool_bytes = 17'(txb);
    rx_pool_bytes = 17'(rxb);
    msize[1] = txb; msize[0] = rxb;
    mmap[0] = '0; mmap[1] = '0;
    for (int c = 0; c < 64; c++) mreg[c] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 ready low in reset", 32'(req_ready), 32'd0);
    rst_n = 1'b1;
    tx_pool_bytes = 17'($urandom);
    rx_pool_bytes = 17'($urandom);
    @(negedge clk);
    chk("R1 done low after reset", 32'(rsp_done), 32'd0);
    @(negedge clk);
    chk("R1 ready high", 32'(req_ready), 32'd1);
    for (int c = 0; c < 64; c += 9) begin
      rd_chan = 6'(c);
      #1 chk("R1 channel reg cleared", rd_desc, 32'd0);
    end
  endtask

  task automatic do_op(bit op, bit dir, int chan, logic [31:0] desc, string tag);
    bit eb = 0, ee = 0;
    logic [31:0] ed = '0;
    int i;
    if (!op) begin
      i = first_free(mmap[dir], msize[dir]);
      if (i < 0) eb = 1;
      else begin
        ed = {16'h0800, 16'(i * 2048)};
        mmap[dir][i] = 1'b1;
        mreg[chan] = ed;
      end
    end else begin
      if (int'(desc[15:0]) >= msize[dir]) ee = 1;
      else mmap[dir][desc[15:11]] = 1'b0;
    end
    req_valid = 1'b1; req_op = op; req_dir = dir;
    req_chan = 6'(chan); req_desc = desc; rd_chan = 6'(chan);
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R9 done"}, 32'(rsp_done), 32'd1);
    chk({tag, " R4 busy"}, 32'(rsp_busy), 32'(eb));
    chk({tag, " R7 err"}, 32'(rsp_err), 32'(ee));
    chk({tag, " R3 desc"}, rsp_desc, ed);
    chk({tag, " R8 chan reg"}, rd_desc, mreg[chan]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    // Phase 1: tx 5000 bytes -> 2 blocks (R2 rounding), rx 64 KiB -> 32 blocks
    do_reset(5000, 65536);
    do_op(0, 1, 3, 0, "R3 tx first");            // base 0
    do_op(0, 1, 4, 0, "R3 tx second");           // base 0x800
    do_op(0, 1, 5, 0, "R4 tx full");             // busy, chan 5 stays 0
    do_op(1, 1, 0, 32'h0800_1400, "R7 tx oob");  // 5120 >= 5000
    do_op(1, 1, 0, 32'h0800_0000, "R6 tx free0");
    do_op(0, 1, 6, 0, "R6 tx reuse");            // base 0 again
    @(negedge clk);
    chk("R9 no done when idle", 32'(rsp_done), 32'd0);
    for (int k = 0; k < 32; k++) do_op(0, 0, k, 0, "R5 rx fill");
    do_op(0, 0, 40, 0, "R4 rx full");
    do_op(1, 0, 0, 32'h0800_5000, "R6 rx mid free");  // block 10
    do_op(0, 0, 41, 0, "R6 rx reuse mid");
    do_op(1, 0, 0, 32'h0800_FFFF, "R6 rx top free");  // block 31
    for (int k = 0; k < 3000; k++) begin
      bit op = 1'($urandom);
      bit dir = 1'($urandom);
      logic [31:0] d = {16'($urandom), 5'($urandom), 11'd0};
      if ($urandom % 8 == 0) d[15:0] = 16'($urandom);
      do_op(op, dir, int'($urandom % 64), d, "rand p1");
    end
    // Phase 2: tx 0 bytes -> always busy; rx 14436 bytes -> 7 blocks
    do_reset(0, 2048 * 7 + 100);
    do_op(0, 1, 1, 0, "R2 zero pool busy");
    do_op(1, 1, 0, 32'h0800_0000, "R7 zero pool free");
    for (int k = 0; k < 8; k++) do_op(0, 0, k, 0, "R2 rx seven");
    for (int k = 0; k < 2000; k++) begin
      bit op = 1'($urandom);
      bit dir = 1'($urandom);
      logic [31:0] d = {16'($urandom), 16'(($urandom % 9) * 2048)};
      do_op(op, dir, int'($urandom % 64), d, "rand p2");
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
    $finish;
  end
endmodule